// File: doc/BRIEF.md
# Converter Start and Low-Power Sequencer

This block is the control engine that sits in front of an analog converter. Software sets a start bit. The sequencer then turns the converter's power on and waits a fixed warm-up interval of 20 clocks. After that it walks a range of configuration slots, issuing one acquisition strobe per slot and waiting for the converter's done pulse before moving on. A sequence-start pulse marks each power-up so that downstream result-storage and interrupt logic can rewind. An end-of-sequence pulse marks the done of the final slot.

In single mode the sequencer drops the start bit itself after one pass and powers down. In continuous mode it loops back to the first slot without repeating the warm-up. Software may clear the start bit at any moment to abort. A stop-mode request overrides everything: power is removed, any conversion in flight is abandoned and the start bit is forced to zero. Once the request is released, nothing happens until software starts the sequencer again.

Top module: `conv_seq`

## Requirements
- R1: After reset, pwrEn, acqStrobe, seqStartPulse, seqEndPulse and startBit are 0, and slotIdx is 0.
- R2: A startSet pulse makes startBit 1 at the next edge. One edge later pwrEn rises, and seqStartPulse is 1 for exactly that first powered cycle. When startClr and startSet arrive in the same cycle, the clear wins.
- R3: pwrEn is high for exactly PWR_CYC (default 20) cycles before the first acqStrobe. acqStrobe is a one-cycle pulse and is only ever high while pwrEn is high.
- R4: The first acquisition uses slotIdx = firstSlot. Each accepted done pulse is followed by the next strobe two cycles later, with slotIdx advanced by one modulo 2^SLOT_W. The walk wraps past the top index when firstSlot > lastSlot.
- R5: seqEndPulse is high in the same cycle as the done pulse accepted while slotIdx equals lastSlot, and at no other time.
- R6: In single mode (contMode = 0), the edge that accepts the final done clears startBit and removes pwrEn.
- R7: In continuous mode (contMode = 1), the final done is followed by a strobe at firstSlot two cycles later, with no new seqStartPulse and with pwrEn held high.
- R8: Clearing startBit through startClr while active returns the sequencer to idle. pwrEn is low two edges after the clear, and no acqStrobe is issued once startBit reads 0.
- R9: While stopReq is high, startBit is 0 and startSet is ignored. From the edge after stopReq rises, pwrEn stays low.
- R10: After stopReq falls, the sequencer stays unpowered until a new startSet arrives.
- R11: A done pulse that arrives while the sequencer is idle, in stop mode, in warm-up, or in the strobe cycle itself has no effect on slotIdx or on any other output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startSet | input | 1 | Software write of 1 to the start bit (pulse) |
| startClr | input | 1 | Software write of 0 to the start bit (pulse) |
| contMode | input | 1 | 1 = continuous sequencing, 0 = single pass |
| stopReq | input | 1 | Low-power stop-mode request (level) |
| convDone | input | 1 | One-cycle pulse marking the end of a conversion |
| firstSlot | input | SLOT_W | First slot index of the sequence |
| lastSlot | input | SLOT_W | Last slot index of the sequence |
| pwrEn | output | 1 | Converter power enable |
| acqStrobe | output | 1 | One-cycle acquisition start |
| slotIdx | output | SLOT_W | Slot being converted |
| seqStartPulse | output | 1 | One-cycle pulse on the first warm-up cycle |
| seqEndPulse | output | 1 | One-cycle pulse on the done of the last slot |
| startBit | output | 1 | Start bit as seen by software, including hardware clears |

## Verification
A wrong warm-up count shifts the first acqStrobe off its expected cycle, so the next per-cycle comparison exposes it within one clock. A state that fails to step or wrap the slot is visible on slotIdx at the next strobe. A missed return to idle on stop, abort or single-pass completion leaves pwrEn or startBit high one or two edges after the event. Because the bench's behavioural model is compared on every clock, any divergence is reported in the cycle it first reaches a port.

// File: rtl/seq_pkg.sv
package seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_POWERUP  = 3'd1,
    ST_CONVERT  = 3'd2,
    ST_NEXT     = 3'd3,
    ST_STOPPED  = 3'd4
  } seqState_t;

  // strobes from the control FSM to the datapath
  typedef struct packed {
    logic cntClr;      // restart warm-up counter
    logic cntInc;      // advance warm-up counter
    logic slotLoad;    // load slot index from firstSlot
    logic slotInc;     // step slot index
    logic waitSet;     // strobe issued, now waiting for done
    logic waitClr;     // leaving conversion wait
    logic startHwClr;  // hardware clear of the start bit
  } dpCtrl_t;

endpackage

// File: rtl/seq_datapath.sv
module seq_datapath
  import seq_pkg::*;
#(
  parameter int PWR_CYC = 20,
  parameter int SLOT_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtrl_t           ctl,
  input  logic              startSet,
  input  logic              startClr,
  input  logic              stopReq,
  input  logic [SLOT_W-1:0] firstSlot,
  output logic              cntLast,
  output logic [SLOT_W-1:0] slotIdx,
  output logic              waiting,
  output logic              startBit
);

  localparam int CNT_W = (PWR_CYC > 1) ? $clog2(PWR_CYC) : 1;
  localparam logic [CNT_W-1:0] CNT_END = CNT_W'(PWR_CYC - 1);

  logic [CNT_W-1:0] pwrCnt;

  // warm-up counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pwrCnt <= '0;
    end else if (ctl.cntClr) begin
      pwrCnt <= '0;
    end else if (ctl.cntInc) begin
      pwrCnt <= pwrCnt + CNT_W'(1);
    end
  end

  assign cntLast = (pwrCnt == CNT_END);

  // slot index, wraps modulo 2^SLOT_W
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      slotIdx <= '0;
    end else if (ctl.slotLoad) begin
      slotIdx <= firstSlot;
    end else if (ctl.slotInc) begin
      slotIdx <= slotIdx + SLOT_W'(1);
    end
  end

  // conversion wait flag
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      waiting <= 1'b0;
    end else if (ctl.waitClr) begin
      waiting <= 1'b0;
    end else if (ctl.waitSet) begin
      waiting <= 1'b1;
    end
  end

  // start bit: every clear source beats a set
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      startBit <= 1'b0;
    end else if (startClr || ctl.startHwClr || stopReq) begin
      startBit <= 1'b0;
    end else if (startSet) begin
      startBit <= 1'b1;
    end
  end

  AST_STOP_CLEARS_START: assert property (@(posedge clk) disable iff (!rstN)
    stopReq |=> !startBit); // R9

  AST_COUNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    pwrCnt <= CNT_END); // R3

endmodule

// File: rtl/seq_ctrl.sv
module seq_ctrl
  import seq_pkg::*;
#(
  parameter int SLOT_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              contMode,
  input  logic              stopReq,
  input  logic              convDone,
  input  logic [SLOT_W-1:0] lastSlot,
  input  logic              cntLast,
  input  logic [SLOT_W-1:0] slotIdx,
  input  logic              waiting,
  input  logic              startBit,
  output dpCtrl_t           ctl,
  output logic              pwrEn,
  output logic              acqStrobe,
  output logic              seqStartPulse,
  output logic              seqEndPulse
);

  seqState_t state, nextState;
  logic      atLast;
  logic      doneTaken;

  assign atLast    = (slotIdx == lastSlot);
  assign doneTaken = (state == ST_CONVERT) && startBit && !stopReq &&
                     waiting && convDone;

  always_comb begin
    nextState = state;
    ctl       = '0;
    if (stopReq) begin
      nextState = ST_STOPPED;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (startBit) begin
            nextState    = ST_POWERUP;
            ctl.cntClr   = 1'b1;
            ctl.slotLoad = 1'b1;
          end
        end
        ST_STOPPED: nextState = ST_IDLE;
        ST_POWERUP: begin
          if (!startBit) begin
            nextState = ST_IDLE;
          end else if (cntLast) begin
            nextState = ST_CONVERT;
          end else begin
            ctl.cntInc = 1'b1;
          end
        end
        ST_CONVERT: begin
          if (!startBit) begin
            nextState = ST_IDLE;
          end else if (!waiting) begin
            ctl.waitSet = 1'b1;
          end else if (convDone) begin
            if (atLast) begin
              if (contMode) begin
                nextState    = ST_NEXT;
                ctl.slotLoad = 1'b1;
              end else begin
                nextState      = ST_IDLE;
                ctl.startHwClr = 1'b1;
              end
            end else begin
              nextState   = ST_NEXT;
              ctl.slotInc = 1'b1;
            end
          end
        end
        ST_NEXT: begin
          nextState = startBit ? ST_CONVERT : ST_IDLE;
        end
        default: nextState = ST_IDLE;
      endcase
    end
    ctl.waitClr = (nextState != ST_CONVERT);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state         <= ST_IDLE;
      seqStartPulse <= 1'b0;
    end else begin
      state         <= nextState;
      seqStartPulse <= (state == ST_IDLE) && (nextState == ST_POWERUP);
    end
  end

  assign pwrEn       = (state == ST_POWERUP) || (state == ST_CONVERT) ||
                       (state == ST_NEXT);
  assign acqStrobe   = ctl.waitSet;
  assign seqEndPulse = doneTaken && atLast;

  AST_STROBE_POWERED: assert property (@(posedge clk) disable iff (!rstN)
    acqStrobe |-> pwrEn); // R3

  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    acqStrobe |=> !acqStrobe); // R3

  AST_STOP_UNPOWERS: assert property (@(posedge clk) disable iff (!rstN)
    stopReq |=> !pwrEn); // R9

  AST_SINGLE_ENDS: assert property (@(posedge clk) disable iff (!rstN)
    (seqEndPulse && !contMode) |=> (!pwrEn && !startBit)); // R6

  AST_START_PULSE_POWERED: assert property (@(posedge clk) disable iff (!rstN)
    seqStartPulse |-> (pwrEn || $past(stopReq) == 1'b0)); // R2

  AST_END_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rstN)
    seqEndPulse |-> (convDone && pwrEn)); // R5

endmodule

// File: rtl/conv_seq.sv
module conv_seq
  import seq_pkg::*;
#(
  parameter int PWR_CYC = 20,
  parameter int SLOT_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startSet,
  input  logic              startClr,
  input  logic              contMode,
  input  logic              stopReq,
  input  logic              convDone,
  input  logic [SLOT_W-1:0] firstSlot,
  input  logic [SLOT_W-1:0] lastSlot,
  output logic              pwrEn,
  output logic              acqStrobe,
  output logic [SLOT_W-1:0] slotIdx,
  output logic              seqStartPulse,
  output logic              seqEndPulse,
  output logic              startBit
);

  dpCtrl_t ctl;
  logic    cntLast;
  logic    waiting;

  seq_ctrl #(.SLOT_W(SLOT_W)) u_ctrl (
    .clk           (clk),
    .rstN          (rstN),
    .contMode      (contMode),
    .stopReq       (stopReq),
    .convDone      (convDone),
    .lastSlot      (lastSlot),
    .cntLast       (cntLast),
    .slotIdx       (slotIdx),
    .waiting       (waiting),
    .startBit      (startBit),
    .ctl           (ctl),
    .pwrEn         (pwrEn),
    .acqStrobe     (acqStrobe),
    .seqStartPulse (seqStartPulse),
    .seqEndPulse   (seqEndPulse)
  );

  seq_datapath #(.PWR_CYC(PWR_CYC), .SLOT_W(SLOT_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .startSet  (startSet),
    .startClr  (startClr),
    .stopReq   (stopReq),
    .firstSlot (firstSlot),
    .cntLast   (cntLast),
    .slotIdx   (slotIdx),
    .waiting   (waiting),
    .startBit  (startBit)
  );

endmodule

// File: tb/conv_seq_tb.sv
`timescale 1ns/1ps
module conv_seq_tb;

  localparam int PWR = 20;
  localparam int SW  = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startSet = 1'b0, startClr = 1'b0, contMode = 1'b0, stopReq = 1'b0;
  logic convDone = 1'b0;
  logic [SW-1:0] firstSlot = '0, lastSlot = '0;
  logic pwrEn, acqStrobe, seqStartPulse, seqEndPulse, startBit;
  logic [SW-1:0] slotIdx;

  always #5 clk = ~clk;

  conv_seq #(.PWR_CYC(PWR), .SLOT_W(SW)) u_dut (
    .clk(clk), .rstN(rstN), .startSet(startSet), .startClr(startClr),
    .contMode(contMode), .stopReq(stopReq), .convDone(convDone),
    .firstSlot(firstSlot), .lastSlot(lastSlot), .pwrEn(pwrEn),
    .acqStrobe(acqStrobe), .slotIdx(slotIdx), .seqStartPulse(seqStartPulse),
    .seqEndPulse(seqEndPulse), .startBit(startBit)
  );

  int errors = 0, checks = 0, cyc = 0;
  string curReq = "R1";
  bit autoDone = 1'b1, strayDone = 1'b0;
  int doneCnt = 0;
  int nStrobe = 0, nStart = 0, nEnd = 0;

  // behavioural reference: 0 idle, 1 warm-up, 2 convert, 3 next, 4 stopped
  int mState = 0, mCnt = 0, mSlot = 0;
  bit mWait = 0, mStart = 0;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mState = 0; mCnt = 0; mSlot = 0; mWait = 0; mStart = 0;
    end else begin
      int nS;
      bit hwClr;
      nS = mState; hwClr = 0;
      if (stopReq) nS = 4;
      else if (mState == 0) begin
        if (mStart) begin nS = 1; mCnt = 0; mSlot = int'(firstSlot); end
      end else if (mState == 4) nS = 0;
      else if (!mStart) nS = 0;
      else if (mState == 1) begin
        if (mCnt == PWR - 1) nS = 2; else mCnt++;
      end else if (mState == 3) nS = 2;
      else if (!mWait) mWait = 1;
      else if (convDone) begin
        if (mSlot == int'(lastSlot)) begin
          if (contMode) begin nS = 3; mSlot = int'(firstSlot); end
          else begin nS = 0; hwClr = 1; end
        end else begin
          nS = 3; mSlot = (mSlot + 1) % (1 << SW);
        end
      end
      if (nS != 2) mWait = 0;
      if (startClr || hwClr || stopReq) mStart = 0;
      else if (startSet) mStart = 1;
      mState = nS;
    end
  end

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic compareAll();
    bit eP, eA, eS, eE;
    eP = (mState >= 1 && mState <= 3);
    eA = (mState == 2) && mStart && !stopReq && !mWait;
    eS = (mState == 1) && (mCnt == 0);
    eE = (mState == 2) && mStart && !stopReq && mWait && convDone &&
         (mSlot == int'(lastSlot));
    check(curReq, "pwrEn", int'(pwrEn), int'(eP));
    check(curReq, "acqStrobe", int'(acqStrobe), int'(eA));
    check(curReq, "seqStartPulse", int'(seqStartPulse), int'(eS));
    check(curReq, "seqEndPulse", int'(seqEndPulse), int'(eE));
    check(curReq, "startBit", int'(startBit), int'(mStart));
    if (eP) check(curReq, "slotIdx", int'(slotIdx), mSlot);
  endtask

  task automatic tick();
    @(negedge clk);
    convDone = (autoDone && doneCnt == 1) || strayDone;
    if (doneCnt > 0) doneCnt--;
    #1;
    compareAll();
    if (acqStrobe) begin doneCnt = 3; nStrobe++; end
    if (seqStartPulse) nStart++;
    if (seqEndPulse) nEnd++;
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic pulseStart();
    startSet = 1'b1; tick(); startSet = 1'b0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected<=%0d cycles", cyc, 20000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int pre;
    // R1 reset state
    #1;
    check("R1", "pwrEn in reset", int'(pwrEn), 0);
    check("R1", "startBit in reset", int'(startBit), 0);
    check("R1", "slotIdx in reset", int'(slotIdx), 0);
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    run(3);

    // R2/R3/R4/R5/R6 single pass over slots 2..4
    curReq = "R2"; firstSlot = 4'd2; lastSlot = 4'd4; contMode = 1'b0;
    nStrobe = 0; nStart = 0; nEnd = 0;
    pulseStart();
    check("R2", "startBit after set", int'(startBit), 1);
    tick();
    check("R2", "pwrEn one edge after startBit", int'(pwrEn), 1);
    check("R2", "seqStartPulse first powered cycle", int'(seqStartPulse), 1);
    curReq = "R3"; pre = 1;
    while (!acqStrobe && pre < 100) begin tick(); if (!acqStrobe) pre++; end
    check("R3", "powered cycles before first strobe", pre, PWR);
    check("R4", "first slot", int'(slotIdx), 2);
    curReq = "R4";
    run(20);
    check("R4", "strobes in single pass", nStrobe, 3);
    check("R5", "end pulses in single pass", nEnd, 1);
    check("R6", "startBit after single pass", int'(startBit), 0);
    check("R6", "pwrEn after single pass", int'(pwrEn), 0);
    check("R2", "start pulses", nStart, 1);

    // R2 clear beats set
    startSet = 1'b1; startClr = 1'b1; tick(); startSet = 1'b0; startClr = 1'b0;
    check("R2", "startBit when set and clear coincide", int'(startBit), 0);
    run(2);

    // R7/R4 continuous with wrap 14,15,0,1
    curReq = "R7"; firstSlot = 4'd14; lastSlot = 4'd1; contMode = 1'b1;
    nStrobe = 0; nStart = 0; nEnd = 0;
    pulseStart();
    run(PWR + 60);
    check("R7", "single warm-up in continuous mode", nStart, 1);
    check("R7", "several sequences ended", int'(nEnd >= 2), 1);
    check("R4", "wrapped strobes", int'(nStrobe >= 8), 1);

    // R8 software abort
    curReq = "R8";
    startClr = 1'b1; tick(); startClr = 1'b0;
    tick();
    check("R8", "pwrEn after abort", int'(pwrEn), 0);
    nStrobe = 0; run(10);
    check("R8", "no strobes after abort", nStrobe, 0);

    // R11 stray done while idle and during warm-up
    curReq = "R11"; autoDone = 1'b0; contMode = 1'b0;
    firstSlot = 4'd5; lastSlot = 4'd6;
    strayDone = 1'b1; run(3); strayDone = 1'b0;
    check("R11", "idle ignores done", int'(pwrEn), 0);
    pulseStart();
    strayDone = 1'b1; run(PWR); strayDone = 1'b0;
    tick();
    check("R11", "slot unchanged by stray done", int'(slotIdx), 5);
    autoDone = 1'b1; doneCnt = 0;
    run(30);

    // R9/R10 stop mode mid-sequence
    curReq = "R9"; contMode = 1'b1; firstSlot = 4'd0; lastSlot = 4'd3;
    pulseStart();
    run(PWR + 8);
    stopReq = 1'b1; startSet = 1'b1; tick(); startSet = 1'b0;
    tick();
    check("R9", "pwrEn in stop", int'(pwrEn), 0);
    check("R9", "startBit in stop", int'(startBit), 0);
    startSet = 1'b1; tick(); startSet = 1'b0;
    check("R9", "set ignored in stop", int'(startBit), 0);
    curReq = "R10"; stopReq = 1'b0;
    run(15);
    check("R10", "idle after stop release", int'(pwrEn), 0);
    contMode = 1'b0;
    pulseStart();
    run(PWR + 30);
    check("R10", "restart completes", int'(startBit), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule